// File: doc/BRIEF.md
# Dual-Processor Mailbox Channel Controller

This block lets two processors signal each other over a set of mailbox channels. Every channel holds one occupancy flag per direction. A processor raises its own flag to announce that a message is waiting. The other processor acknowledges by clearing that flag. Each processor has its own small register bank: an interrupt-enable register, a mask register, a write-only command register and a status register. Both banks, plus a configuration word and a version word, sit in one address map. Each processor reaches that map through its own APB-style port.

Each processor gets two level interrupts, both computed from the same flags. The receive interrupt reports flags that the peer has raised and that this processor has not masked. The transmit-free interrupt reports this processor's own flags that the peer has already cleared. A sender raises its flag and unmasks its transmit-free interrupt. It then waits for that interrupt to learn that the receiver has consumed the message.

Top module: `mbox_dual_ctrl`

## Requirements
- R1: After reset, all occupancy flags are 0. Both interrupt enables of both processors are 0. All 32 mask bits of both banks are 1, so all four interrupt outputs are low.
- R2: The bank for processor p occupies byte addresses 0x10*p to 0x10*p+0xC. Address bits [3:2] select the word: 0 enable, 1 mask, 2 command, 3 status. A write takes effect on the clock edge at which sel, enable and write are all high. Read data follows the address combinationally. Either port may read either bank. A write that a port makes into the other processor's bank is ignored.
- R3: In the enable register, bit 0 is the receive interrupt enable and bit 16 is the transmit-free interrupt enable. All other bits read as 0.
- R4: The mask register stores all 32 bits written to it. Bit n masks the receive interrupt of channel n. Bit 16+n masks the transmit-free interrupt of channel n. A 1 means masked.
- R5: Writing 1 to command bit 16+n sets the writer's own occupancy flag for channel n.
- R6: Writing 1 to command bit n clears the other processor's occupancy flag for channel n. Command bits written as 0 change nothing. The command register always reads as 0.
- R7: The status register returns the reading bank's own occupancy flags in bits [NCH-1:0]. All higher bits read as 0.
- R8: A processor's receive interrupt is high exactly when its receive enable is 1 and some channel n has the peer's flag set and this processor's mask bit n clear.
- R9: A processor's transmit-free interrupt is high exactly when its transmit-free enable is 1 and some channel n has this processor's own flag clear and its mask bit 16+n clear.
- R10: Address 0x3F0 reads NCH in bits [7:0]. Address 0x3F4 reads the major revision in bits [7:4] and the minor revision in bits [3:0]. Writes to these addresses change nothing. Any other unmapped address reads 0.
- R11: Command bits that name a channel at or above NCH are ignored.
- R12: Writes from both ports in the same cycle are all applied. If one processor sets a flag in the same cycle that its peer clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p0_sel | input | 1 | Processor 0 port select |
| p0_enable | input | 1 | Processor 0 access phase |
| p0_write | input | 1 | Processor 0 write (1) or read (0) |
| p0_addr | input | AW | Processor 0 byte address |
| p0_wdata | input | 32 | Processor 0 write data |
| p0_rdata | output | 32 | Processor 0 read data |
| p1_sel | input | 1 | Processor 1 port select |
| p1_enable | input | 1 | Processor 1 access phase |
| p1_write | input | 1 | Processor 1 write (1) or read (0) |
| p1_addr | input | AW | Processor 1 byte address |
| p1_wdata | input | 32 | Processor 1 write data |
| p1_rdata | output | 32 | Processor 1 read data |
| p0_rx_irq | output | 1 | Processor 0 receive interrupt (level) |
| p0_tx_irq | output | 1 | Processor 0 transmit-free interrupt (level) |
| p1_rx_irq | output | 1 | Processor 1 receive interrupt (level) |
| p1_tx_irq | output | 1 | Processor 1 transmit-free interrupt (level) |

## Verification
The assertions assume that reset stays active until the first access. They also assume that no port drives a write while reset is low. Under those conditions, the set and clear properties can trust the previous cycle's command decode. The assertions do not rely on the two ports being coordinated. The stimulus therefore issues fully concurrent random writes from both ports, including writes into the wrong bank and into the read-only words. Every access is a two-phase setup/access sequence with word-aligned addresses inside the decoded range, and reset is released only once before traffic starts.

// File: rtl/mbox_dual_ctrl.sv
module mbox_dual_ctrl #(
  parameter int unsigned NCH       = 16,
  parameter int unsigned AW        = 10,
  parameter logic [3:0]  VER_MAJOR = 4'd1,
  parameter logic [3:0]  VER_MINOR = 4'd0
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p0_sel,
  input  logic          p0_enable,
  input  logic          p0_write,
  input  logic [AW-1:0] p0_addr,
  input  logic [31:0]   p0_wdata,
  output logic [31:0]   p0_rdata,
  input  logic          p1_sel,
  input  logic          p1_enable,
  input  logic          p1_write,
  input  logic [AW-1:0] p1_addr,
  input  logic [31:0]   p1_wdata,
  output logic [31:0]   p1_rdata,
  output logic          p0_rx_irq,
  output logic          p0_tx_irq,
  output logic          p1_rx_irq,
  output logic          p1_tx_irq
);
  localparam logic [AW-1:0] CFG_ADDR = AW'(12'h3F0);
  localparam logic [AW-1:0] VER_ADDR = AW'(12'h3F4);

  logic [1:0]     acc;
  logic [AW-1:0]  addr  [2];
  logic [31:0]    wdata [2];
  logic [31:0]    rdata [2];
  logic [1:0]     rxen, txen, rx_irq, tx_irq;
  logic [1:0]     wr_ctrl, wr_mask, wr_cmd;
  logic [31:0]    mask  [2];
  logic [NCH-1:0] occ [2], set_own [2], clr_peer [2];

  assign acc      = {p1_sel & p1_enable & p1_write, p0_sel & p0_enable & p0_write};
  assign addr[0]  = p0_addr;
  assign addr[1]  = p1_addr;
  assign wdata[0] = p0_wdata;
  assign wdata[1] = p1_wdata;
  assign p0_rdata = rdata[0];
  assign p1_rdata = rdata[1];
  assign p0_rx_irq = rx_irq[0];
  assign p0_tx_irq = tx_irq[0];
  assign p1_rx_irq = rx_irq[1];
  assign p1_tx_irq = tx_irq[1];

  function automatic logic [31:0] rd_word(input logic [AW-1:0] a);
    logic b;
    b = a[4];
    rd_word = '0;
    if (a[AW-1:5] == '0) begin
      case (a[3:2])
        2'd0: rd_word = {15'b0, txen[b], 15'b0, rxen[b]};
        2'd1: rd_word = mask[b];
        2'd3: rd_word[NCH-1:0] = occ[b];
        default: rd_word = '0;
      endcase
    end else if (a == CFG_ADDR) rd_word = 32'(NCH);
    else if (a == VER_ADDR) rd_word = {24'b0, VER_MAJOR, VER_MINOR};
  endfunction

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      logic own;
      own = acc[p] && addr[p][AW-1:5] == '0 && addr[p][4] == p[0];
      wr_ctrl[p]  = own && addr[p][3:2] == 2'd0;
      wr_mask[p]  = own && addr[p][3:2] == 2'd1;
      wr_cmd[p]   = own && addr[p][3:2] == 2'd2;
      set_own[p]  = wr_cmd[p] ? wdata[p][16 +: NCH] : '0;
      clr_peer[p] = wr_cmd[p] ? wdata[p][NCH-1:0] : '0;
      rdata[p]    = rd_word(addr[p]);
      rx_irq[p]   = rxen[p] & |(occ[1-p] & ~mask[p][NCH-1:0]);
      tx_irq[p]   = txen[p] & |(~occ[p] & ~mask[p][16 +: NCH]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxen <= '0;
      txen <= '0;
      for (int p = 0; p < 2; p++) begin
        mask[p] <= '1;
        occ[p]  <= '0;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (wr_ctrl[p]) begin
          rxen[p] <= wdata[p][0];
          txen[p] <= wdata[p][16];
        end
        if (wr_mask[p]) mask[p] <= wdata[p];
        occ[p] <= (occ[p] & ~clr_peer[1-p]) | set_own[p];
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_chk
    localparam int Q = 1 - p;

    a_r5_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (set_own[p] != '0) |=> ((occ[p] & $past(set_own[p])) == $past(set_own[p])));

    a_r6_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_peer[Q] & ~set_own[p]) != '0) |=> ((occ[p] & $past(clr_peer[Q] & ~set_own[p])) == '0));

    a_r6_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (addr[p][AW-1:5] == '0 && addr[p][3:2] == 2'd2) |-> (rdata[p] == '0));

    a_r2_foreign_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (acc[Q] && addr[Q][AW-1:5] == '0 && addr[Q][4] == p[0] && !acc[p])
      |=> ($stable(mask[p]) && $stable(rxen[p]) && $stable(txen[p]) && $stable(occ[p])));

    a_r8_rx_needs_peer_flag: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq[p] |-> (rxen[p] && occ[Q] != '0));

    a_r9_tx_needs_free_flag: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq[p] |-> (txen[p] && occ[p] != '1));
  end
endmodule

// File: tb/mbox_dual_ctrl_tb_top.sv
`timescale 1ns/1ps
module mbox_dual_ctrl_tb_top;
  localparam int NCH = 12;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        sel [2], en [2], wr [2];
  logic [9:0]  addr [2];
  logic [31:0] wd [2], rd [2];
  logic        rx [2], tx [2];

  mbox_dual_ctrl #(.NCH(NCH), .AW(10), .VER_MAJOR(4'd1), .VER_MINOR(4'd0)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .p0_sel(sel[0]), .p0_enable(en[0]), .p0_write(wr[0]), .p0_addr(addr[0]), .p0_wdata(wd[0]), .p0_rdata(rd[0]),
    .p1_sel(sel[1]), .p1_enable(en[1]), .p1_write(wr[1]), .p1_addr(addr[1]), .p1_wdata(wd[1]), .p1_rdata(rd[1]),
    .p0_rx_irq(rx[0]), .p0_tx_irq(tx[0]), .p1_rx_irq(rx[1]), .p1_tx_irq(tx[1]));

  int checks = 0, fails = 0;
  logic [NCH-1:0] m_occ [2];
  logic [31:0]    m_mask [2];
  logic           m_rxen [2], m_txen [2];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [9:0] a);
    logic b;
    b = a[4];
    exp_rd = 0;
    if (a[9:5] == 0) begin
      case (a[3:2])
        2'd0: exp_rd = {15'b0, m_txen[b], 15'b0, m_rxen[b]};
        2'd1: exp_rd = m_mask[b];
        2'd3: exp_rd = {20'b0, m_occ[b]};
        default: exp_rd = 0;
      endcase
    end else if (a == 10'h3F0) exp_rd = NCH;
    else if (a == 10'h3F4) exp_rd = 32'h10;
  endfunction

  function automatic logic exp_rx(input int p);
    return m_rxen[p] & |(m_occ[1-p] & ~m_mask[p][NCH-1:0]);
  endfunction
  function automatic logic exp_tx(input int p);
    return m_txen[p] & |(~m_occ[p] & ~m_mask[p][16 +: NCH]);
  endfunction

  task automatic cyc(input logic w0, input logic [9:0] a0, input logic [31:0] d0,
                     input logic w1, input logic [9:0] a1, input logic [31:0] d1);
    logic [NCH-1:0] s [2], c [2];
    logic w [2];
    @(negedge clk);
    w[0] = w0; w[1] = w1;
    addr[0] = a0; wd[0] = d0; addr[1] = a1; wd[1] = d1;
    for (int p = 0; p < 2; p++) begin sel[p] = w[p]; wr[p] = w[p]; en[p] = 0; end
    @(negedge clk);
    for (int p = 0; p < 2; p++) en[p] = w[p];
    @(negedge clk);
    for (int p = 0; p < 2; p++) begin sel[p] = 0; en[p] = 0; wr[p] = 0; end
    for (int p = 0; p < 2; p++) begin
      s[p] = 0; c[p] = 0;
      if (w[p] && addr[p][9:5] == 0 && addr[p][4] == p[0]) begin
        case (addr[p][3:2])
          2'd0: begin m_rxen[p] = wd[p][0]; m_txen[p] = wd[p][16]; end
          2'd1: m_mask[p] = wd[p];
          2'd2: begin s[p] = wd[p][16 +: NCH]; c[p] = wd[p][NCH-1:0]; end
          default: ;
        endcase
      end
    end
    for (int p = 0; p < 2; p++) m_occ[p] = (m_occ[p] & ~c[1-p]) | s[p];
  endtask

  task automatic rdp(input int q, input logic [9:0] a, output logic [31:0] v);
    @(negedge clk);
    addr[q] = a;
    #1 v = rd[q];
  endtask

  task automatic wr1(input int q, input logic [9:0] a, input logic [31:0] d);
    if (q == 0) cyc(1, a, d, 0, 10'h0, 0);
    else        cyc(0, 10'h0, 0, 1, a, d);
  endtask

  task automatic check_all();
    logic [31:0] v;
    string tag [4] = '{"R3", "R4", "R6", "R7"};
    for (int q = 0; q < 2; q++)
      for (int b = 0; b < 2; b++)
        for (int o = 0; o < 4; o++) begin
          rdp(q, 10'(b * 16 + o * 4), v);
          chk(tag[o], v, exp_rd(10'(b * 16 + o * 4)));
        end
    for (int p = 0; p < 2; p++) begin
      chk("R8", 32'(rx[p]), 32'(exp_rx(p)));
      chk("R9", 32'(tx[p]), 32'(exp_tx(p)));
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7731));
    for (int p = 0; p < 2; p++) begin
      sel[p] = 0; en[p] = 0; wr[p] = 0; addr[p] = 0; wd[p] = 0;
      m_occ[p] = 0; m_mask[p] = '1; m_rxen[p] = 0; m_txen[p] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int b = 0; b < 2; b++) begin
      rdp(0, 10'(b * 16 + 4), v); chk("R1 mask", v, 32'hFFFF_FFFF);
      rdp(1, 10'(b * 16),     v); chk("R1 enable", v, 0);
      rdp(0, 10'(b * 16 + 12), v); chk("R1 status", v, 0);
      chk("R1 irq", {rx[b], tx[b]}, 0);
    end
    // R10: configuration and version words, read-only
    rdp(0, 10'h3F0, v); chk("R10 cfg", v, NCH);
    rdp(1, 10'h3F4, v); chk("R10 ver", v, 32'h10);
    wr1(0, 10'h3F0, 32'hFF);
    rdp(0, 10'h3F0, v); chk("R10 cfg write ignored", v, NCH);
    rdp(0, 10'h200, v); chk("R10 unmapped", v, 0);

    // R3/R4/R9: enable and unmask, transmit-free fires with flags clear
    wr1(0, 10'h00, 32'h0001_0001);
    wr1(0, 10'h04, 32'h0);
    wr1(1, 10'h10, 32'h0001_0001);
    wr1(1, 10'h14, 32'h0);
    chk("R9 tx free", 32'(tx[0]), 1);
    chk("R8 rx idle", 32'(rx[1]), 0);

    // R5/R8: processor 0 posts on channel 3
    wr1(0, 10'h08, 32'h1 << 19);
    rdp(1, 10'h0C, v); chk("R5 own flag set", v, 32'h8);
    chk("R8 peer rx", 32'(rx[1]), 1);

    // R6: zero write no effect, command reads zero
    wr1(1, 10'h18, 32'h0);
    rdp(0, 10'h0C, v); chk("R6 zero write", v, 32'h8);
    rdp(1, 10'h18, v); chk("R6 cmd reads zero", v, 0);
    wr1(1, 10'h18, 32'h1 << 3);
    rdp(0, 10'h0C, v); chk("R6 peer clear", v, 0);
    chk("R8 rx drops", 32'(rx[1]), 0);

    // R2: foreign-bank write ignored
    wr1(1, 10'h04, 32'hFFFF_FFFF);
    rdp(0, 10'h04, v); chk("R2 foreign write", v, 0);

    // R11: channels at or above NCH ignored
    wr1(0, 10'h08, 32'hF000_0000);
    rdp(0, 10'h0C, v); chk("R11 high set ignored", v, 0);

    // R12: concurrent set and clear, set wins; both sides in one cycle
    cyc(1, 10'h08, 32'h1 << 21, 1, 10'h18, 32'h1 << 5);
    rdp(0, 10'h0C, v); chk("R12 set wins", v, 32'h20);
    cyc(1, 10'h08, 32'h1 << 22, 1, 10'h18, 32'h1 << 22);
    rdp(0, 10'h0C, v); chk("R12 both p0", v, 32'h60);
    rdp(1, 10'h1C, v); chk("R12 both p1", v, 32'h40);
    cyc(1, 10'h08, 32'h40, 1, 10'h18, 32'h60);
    rdp(0, 10'h0C, v); chk("R12 cross clear p0", v, 0);
    rdp(1, 10'h1C, v); chk("R12 cross clear p1", v, 0);

    // R4/R8: receive mask suppresses
    wr1(0, 10'h08, 32'h1 << 16);
    wr1(1, 10'h14, 32'h1);
    chk("R8 masked rx", 32'(rx[1]), 0);
    check_all();

    // random concurrent traffic
    for (int i = 0; i < 300; i++) begin
      logic [9:0] a [2];
      logic w [2];
      for (int p = 0; p < 2; p++) begin
        w[p] = ($urandom % 10) < 6;
        a[p] = ($urandom % 16 == 0) ? 10'h3F0 : 10'(($urandom % 2) * 16 + ($urandom % 4) * 4);
      end
      cyc(w[0], a[0], $urandom, w[1], a[1], $urandom);
      check_all();
    end
    finish_run();
  end
endmodule